// File: doc/BRIEF.md
# Store Write Buffer with Read-Miss Forwarding

This block is a small first-in first-out queue that sits between a write-through cache and a slower lower-level memory. Every processor store is pushed into it, whether the cache hit or not, so the processor does not wait for the memory write to finish. With no-write-allocate, a store that misses the cache allocates no line and only enters this queue. The queue empties toward memory one entry at a time over a valid/ready drain port, strictly in the order the stores arrived. Equal addresses are never merged: each store is its own entry.

When the cache takes a read miss, the miss logic presents the address on a lookup port before it goes to memory. If any held entry carries that address, the block reports a hit and returns the data of the youngest such entry, so the read sees the latest store that has not yet reached memory. The processor is stalled only when every entry is occupied and no entry leaves in that cycle. An empty flag lets fence or flush logic wait until all pending stores have drained.

Top module: `wbuf_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, buf_empty is 1 and mem_valid, st_stall and lk_hit are 0.
- R2: Every accepted store appears on mem_addr/mem_data exactly once, in the order the stores were accepted, and one entry leaves on each cycle where mem_valid and mem_ready are both 1.
- R3: The queue holds DEPTH entries (default 4). st_stall is 1 exactly when all DEPTH entries are occupied and mem_ready is 0. A store presented while st_stall is 1 is not accepted.
- R4: When all entries are occupied and mem_ready is 1, st_stall is 0 and a store presented in that cycle is accepted while the oldest entry drains.
- R5: mem_valid is 1 exactly when at least one entry is held, and while mem_valid is 1 and mem_ready is 0 the drain address and data stay unchanged into the next cycle.
- R6: lk_hit is 1 when any held entry's address equals lk_addr; lk_data then carries the data of the most recently accepted matching entry.
- R7: The lookup is combinational over the entries held at the start of the cycle: an entry draining in that cycle still matches, a store accepted in that cycle does not match until the next cycle.
- R8: buf_empty is 1 exactly when no entry is held.
- R9: Stores to an address already held are queued as separate entries (no merging), so N stores need N drain handshakes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| st_valid | input | 1 | Processor presents a store |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data word |
| st_stall | output | 1 | Store cannot be accepted this cycle |
| lk_addr | input | ADDR_W | Read-miss lookup address |
| lk_hit | output | 1 | A held entry matches lk_addr |
| lk_data | output | DATA_W | Data of the youngest matching entry |
| mem_valid | output | 1 | Oldest entry offered to memory |
| mem_ready | input | 1 | Memory accepts the offered entry |
| mem_addr | output | ADDR_W | Address of the oldest entry |
| mem_data | output | DATA_W | Data of the oldest entry |
| buf_empty | output | 1 | No entry is held |

## Verification
A wrong occupancy count shows up at once: st_stall rises too early or too late, buf_empty disagrees with mem_valid's history, or a store is lost or duplicated, which the drain sequence reveals within DEPTH handshakes. A wrong read pointer puts a stale or out-of-order word on mem_addr/mem_data in the very cycle it is offered. A wrong age order in the forwarding search shows as an older data word on lk_data whenever two held entries share an address, visible in the same cycle as the lookup; the bench keeps such duplicates common by drawing addresses from a four-word set.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // What happens to the occupancy in one cycle
    typedef enum logic [1:0] {
        OCC_HOLD = 2'b00,
        OCC_PUSH = 2'b01,
        OCC_POP  = 2'b10,
        OCC_SWAP = 2'b11
    } occ_op_e;

    localparam int unsigned DEF_ADDR_W = 32;
    localparam int unsigned DEF_DATA_W = 32;
    localparam int unsigned DEF_DEPTH  = 4;

    function automatic occ_op_e decode_op(input logic push, input logic pop);
        occ_op_e op;
        unique case ({pop, push})
            2'b00:   op = OCC_HOLD;
            2'b01:   op = OCC_PUSH;
            2'b10:   op = OCC_POP;
            default: op = OCC_SWAP;
        endcase
        return op;
    endfunction

    function automatic int unsigned ptr_bits(input int unsigned depth);
        return (depth <= 1) ? 1 : $clog2(depth);
    endfunction

endpackage

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl #(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned PTR_W = 2,
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic             drain_rdy,
    output logic             push_ok,
    output logic             pop,
    output logic             stall,
    output logic             full,
    output logic             empty,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] occ
);
    import wbuf_pkg::*;

    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    occ_op_e op;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        full    = (occ == FULL_CNT);
        empty   = (occ == '0);
        pop     = !empty && drain_rdy;
        stall   = full && !drain_rdy;
        push_ok = push_req && !stall;
        op      = decode_op(push_ok, pop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            case (op)
                OCC_PUSH: begin
                    wr_ptr <= bump(wr_ptr);
                    occ    <= occ + 1'b1;
                end
                OCC_POP: begin
                    rd_ptr <= bump(rd_ptr);
                    occ    <= occ - 1'b1;
                end
                OCC_SWAP: begin
                    wr_ptr <= bump(wr_ptr);
                    rd_ptr <= bump(rd_ptr);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned PTR_W  = 2,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  logic [PTR_W-1:0]             wr_ptr,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [PTR_W-1:0]             rd_ptr,
    output logic [ADDR_W-1:0]            head_addr,
    output logic [DATA_W-1:0]            head_data,
    output logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    output logic [DEPTH-1:0][DATA_W-1:0] slot_data
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_addr[s] <= '0;
                slot_data[s] <= '0;
            end else if (we && (wr_ptr == PTR_W'(s))) begin
                slot_addr[s] <= wr_addr;
                slot_data[s] <= wr_data;
            end
        end
    end

    always_comb begin
        head_addr = slot_addr[rd_ptr];
        head_data = slot_data[rd_ptr];
    end

endmodule

// File: rtl/wbuf_fwd.sv
module wbuf_fwd #(
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned PTR_W  = 2,
    parameter int unsigned CNT_W  = 3,
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [DEPTH-1:0][DATA_W-1:0] slot_data,
    input  logic [PTR_W-1:0]             rd_ptr,
    input  logic [CNT_W-1:0]             occ,
    input  logic [ADDR_W-1:0]            query,
    output logic                         hit,
    output logic [DATA_W-1:0]            data
);

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PTR_W-1:0] slot;
            slot = PTR_W'((int'(rd_ptr) + k) % DEPTH);
            if ((k < int'(occ)) && (slot_addr[slot] == query)) begin
                hit  = 1'b1;
                data = slot_data[slot];
            end
        end
    end

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top #(
    parameter int unsigned ADDR_W = wbuf_pkg::DEF_ADDR_W,
    parameter int unsigned DATA_W = wbuf_pkg::DEF_DATA_W,
    parameter int unsigned DEPTH  = wbuf_pkg::DEF_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [DATA_W-1:0] st_data,
    output logic              st_stall,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              buf_empty
);

    localparam int unsigned PTR_W = wbuf_pkg::ptr_bits(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic                         push_ok;
    logic                         pop;
    logic                         full;
    logic                         empty;
    logic [PTR_W-1:0]             wr_ptr;
    logic [PTR_W-1:0]             rd_ptr;
    logic [CNT_W-1:0]             occ;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [DEPTH-1:0][DATA_W-1:0] slot_data;

    wbuf_ctrl #(
        .DEPTH (DEPTH),
        .PTR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .push_req  (st_valid),
        .drain_rdy (mem_ready),
        .push_ok   (push_ok),
        .pop       (pop),
        .stall     (st_stall),
        .full      (full),
        .empty     (empty),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .occ       (occ)
    );

    wbuf_store #(
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (push_ok),
        .wr_ptr    (wr_ptr),
        .wr_addr   (st_addr),
        .wr_data   (st_data),
        .rd_ptr    (rd_ptr),
        .head_addr (mem_addr),
        .head_data (mem_data),
        .slot_addr (slot_addr),
        .slot_data (slot_data)
    );

    wbuf_fwd #(
        .DEPTH  (DEPTH),
        .PTR_W  (PTR_W),
        .CNT_W  (CNT_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fwd (
        .slot_addr (slot_addr),
        .slot_data (slot_data),
        .rd_ptr    (rd_ptr),
        .occ       (occ),
        .query     (lk_addr),
        .hit       (lk_hit),
        .data      (lk_data)
    );

    always_comb begin
        mem_valid = !empty;
        buf_empty = empty;
    end

    logic unused_ok;
    always_comb unused_ok = ^{full, pop};

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 4,
    parameter int unsigned CNT_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              st_valid,
    input logic              st_stall,
    input logic              lk_hit,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              buf_empty,
    input logic [CNT_W-1:0]  occ
);

    logic [CNT_W-1:0] acc_n;
    logic [CNT_W-1:0] drn_n;
    always_comb begin
        acc_n = CNT_W'(st_valid && !st_stall);
        drn_n = CNT_W'(mem_valid && mem_ready);
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    assert_stall_only_full_R3: assert property (@(posedge clk) disable iff (rst)
        st_stall |-> (occ == CNT_W'(DEPTH)) && !mem_ready);

    assert_full_drain_accepts_R4: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH)) && mem_ready |-> !st_stall);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> occ == $past(occ) + $past(acc_n) - $past(drn_n));

    assert_drain_hold_R5: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));

    assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        buf_empty |-> !mem_valid && !lk_hit);

endmodule

bind wbuf_top wbuf_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st_valid  (st_valid),
    .st_stall  (st_stall),
    .lk_hit    (lk_hit),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .buf_empty (buf_empty),
    .occ       (occ)
);

// File: tb/wbuf_top_bench.sv
module wbuf_top_bench;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        st_valid;
    logic [31:0] st_addr;
    logic [31:0] st_data;
    logic        st_stall;
    logic [31:0] lk_addr;
    logic        lk_hit;
    logic [31:0] lk_data;
    logic        mem_valid;
    logic        mem_ready;
    logic [31:0] mem_addr;
    logic [31:0] mem_data;
    logic        buf_empty;

    int checks = 0;
    int errors = 0;

    logic [31:0] qa[$];
    logic [31:0] qd[$];

    always #5 clk = ~clk;

    wbuf_top #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH)) u_wbuf_top (
        .clk       (clk),
        .rst       (rst),
        .st_valid  (st_valid),
        .st_addr   (st_addr),
        .st_data   (st_data),
        .st_stall  (st_stall),
        .lk_addr   (lk_addr),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .mem_valid (mem_valid),
        .mem_ready (mem_ready),
        .mem_addr  (mem_addr),
        .mem_data  (mem_data),
        .buf_empty (buf_empty)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [32:0] model_lookup(input logic [31:0] a);
        logic [32:0] r;
        r = '0;
        foreach (qa[i]) if (qa[i] == a) r = {1'b1, qd[i]};
        return r;
    endfunction

    // One cycle: drive at the falling edge, check, then update the model after the rising edge.
    task automatic step(input logic sv, input logic [31:0] sa, input logic [31:0] sd,
                        input logic rdy, input logic [31:0] la);
        int n;
        logic exp_stall;
        logic [32:0] lk;
        @(negedge clk);
        st_valid = sv; st_addr = sa; st_data = sd; mem_ready = rdy; lk_addr = la;
        #1;
        n = qa.size();
        exp_stall = (n == DEPTH) && !rdy;
        chk(st_stall == exp_stall, (n == DEPTH && rdy) ? "R4" : "R3", 32'(st_stall), 32'(exp_stall));
        chk(mem_valid == (n != 0), "R5", 32'(mem_valid), 32'(n != 0));
        if (n != 0) begin
            chk(mem_addr == qa[0], "R2", mem_addr, qa[0]);
            chk(mem_data == qd[0], "R2", mem_data, qd[0]);
        end
        chk(buf_empty == (n == 0), "R8", 32'(buf_empty), 32'(n == 0));
        lk = model_lookup(la);
        chk(lk_hit == lk[32], "R6/R7", 32'(lk_hit), 32'(lk[32]));
        if (lk[32]) chk(lk_data == lk[31:0], "R6", lk_data, lk[31:0]);
        @(posedge clk);
        if (n != 0 && rdy) begin
            void'(qa.pop_front());
            void'(qd.pop_front());
        end
        if (sv && !exp_stall) begin
            qa.push_back(sa);
            qd.push_back(sd);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; st_valid = 0; st_addr = 0; st_data = 0; mem_ready = 0; lk_addr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: outputs during reset
        chk(buf_empty == 1'b1, "R1", 32'(buf_empty), 1);
        chk(mem_valid == 1'b0, "R1", 32'(mem_valid), 0);
        chk(st_stall == 1'b0, "R1", 32'(st_stall), 0);
        chk(lk_hit == 1'b0, "R1", 32'(lk_hit), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(buf_empty == 1'b1 && mem_valid == 1'b0, "R1", 32'(buf_empty), 1);

        // Fill to capacity with memory not ready, then one more store stalls (R3)
        for (int i = 0; i < DEPTH; i++) step(1'b1, 32'h40 + 32'(4*i), 32'hA0 + 32'(i), 1'b0, 32'h40);
        step(1'b1, 32'h80, 32'hBAD0, 1'b0, 32'h4C);
        chk(st_stall == 1'b1, "R3", 32'(st_stall), 1);
        // Full with drain: store accepted without stall (R4)
        step(1'b1, 32'h84, 32'hC001, 1'b1, 32'h84);
        // Drain everything
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 0, 0, 1'b1, 32'h84);

        // R7: store and lookup of the same address in one cycle: no hit yet
        step(1'b1, 32'h30, 32'h1111, 1'b0, 32'h30);
        @(negedge clk); mem_ready = 1'b0; lk_addr = 32'h30; st_valid = 1'b0; #1;
        chk(lk_hit == 1'b1 && lk_data == 32'h1111, "R7", lk_data, 32'h1111);
        @(posedge clk);
        // R7: entry draining this cycle still matches
        @(negedge clk); mem_ready = 1'b1; #1;
        chk(lk_hit == 1'b1, "R7", 32'(lk_hit), 1);
        @(posedge clk);
        void'(qa.pop_front()); void'(qd.pop_front());

        // R9 / R6: three stores to one address, youngest forwarded, three handshakes
        step(1'b1, 32'h20, 32'd1, 1'b0, 32'h20);
        step(1'b1, 32'h20, 32'd2, 1'b0, 32'h20);
        step(1'b1, 32'h20, 32'd3, 1'b0, 32'h20);
        step(1'b0, 0, 0, 1'b1, 32'h20);
        step(1'b0, 0, 0, 1'b1, 32'h20);
        @(negedge clk); mem_ready = 1'b0; #1;
        chk(buf_empty == 1'b0 && mem_data == 32'd3, "R9", mem_data, 32'd3);
        step(1'b0, 0, 0, 1'b1, 32'h20);
        @(negedge clk); #1;
        chk(buf_empty == 1'b1, "R9", 32'(buf_empty), 1);

        // Random traffic over a small address set
        for (int c = 0; c < 3000; c++) begin
            logic [31:0] a, l;
            a = 32'h10 + 32'(4 * ($urandom % 4));
            l = 32'h10 + 32'(4 * ($urandom % 4));
            step(($urandom % 3) != 0, a, $urandom, ($urandom % 2) == 1, l);
        end
        for (int i = 0; i < DEPTH + 1; i++) step(1'b0, 0, 0, 1'b1, 32'h10);
        @(negedge clk); #1;
        chk(buf_empty == 1'b1, "R8", 32'(buf_empty), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule